// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Level Driver

This block turns a segment image held in RAM into per-pin drive-level codes for a multiplexed liquid-crystal panel with four common lines and a parameterised number of segment lines (25 by default). It supports a static mode and 1/2, 1/3 and 1/4 multiplexing. Each multiplexed mode uses either a half or a third bias. Every common and segment pin gets a 2-bit code. The code picks one of the bias rails, which are generated outside the block. Drive polarity flips every frame, so the panel never carries a net DC voltage.

A one-cycle strobe from a clock-divider tap moves the driver from one common phase to the next. At the start of each phase the block captures the RAM row for that phase. Commons past the active count are parked. Any segment pin can be handed to general-purpose output. Such a pin then drives a plain high or low code taken from a registered data input. Reset shows a build-time pattern, either all segments lit or all segments dark.

Top module: `lcd_mux_driver`

## Requirements
- R1: The `mode` input selects the drive scheme: 0 is static with 1 common, 1 is half bias with 2 commons, 2 is half bias with 3 commons, 3 is half bias with 4 commons, 4 is third bias with 3 commons and 5 is third bias with 4 commons. Commons at or above the active count always output code 0.
- R2: Level codes are 0 for ground, 1 for the lower middle rail, 2 for the upper middle rail and 3 for full swing. The active common whose index equals the current phase outputs 3 when polarity is 0 and 0 when polarity is 1. Exactly one active common is in that state at any time.
- R3: An active common that is not selected outputs 1 in half-bias modes, whatever the polarity. In third-bias modes it outputs 1 when polarity is 0 and 2 when polarity is 1.
- R4: A segment pin in LCD use whose latched bit is 1 outputs 0 when polarity is 0 and 3 when polarity is 1. A dark segment in a third-bias mode outputs 2 when polarity is 0 and 1 when polarity is 1. A dark segment in static or half-bias mode outputs 3 when polarity is 0 and 0 when polarity is 1.
- R5: A cycle with `tick` high moves the phase by one. After the last active phase the phase returns to 0 and polarity inverts. Without a tick, phase and polarity hold.
- R6: `seg_ram` holds row c in bits [c*NSEG +: NSEG], with bit s of a row belonging to segment s. The row for a phase is captured on the edge that enters that phase. A change to `seg_ram` during a phase does not reach the outputs until the next phase starts.
- R7: A change in `mode` restarts the frame on the next edge. Phase and polarity become 0 and row 0 is captured. Any tick in that same cycle is ignored.
- R8: While `rst` is high, phase and polarity are 0 and every latched segment bit equals RESET_LIT. Every general-purpose level equals GPIO_RST. This pattern stays until the first tick or mode change.
- R9: A pin whose `gpio_sel` bit is 1 outputs 3 or 0 according to the `gpio_data` bit registered on the previous edge. This does not depend on ticks or mode. The selection itself takes effect at once.
- R10: Mode values 6 and 7 behave exactly like static mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe from the divider tap that advances the phase |
| mode | input | 3 | Drive scheme select |
| seg_ram | input | 4*NSEG | Segment image, one NSEG-bit row per common |
| gpio_sel | input | NSEG | Per-pin hand-over to general-purpose output |
| gpio_data | input | NSEG | General-purpose output levels |
| com_lvl | output | 8 | 2-bit level code per common, common c at [2c+:2] |
| seg_lvl | output | 2*NSEG | 2-bit level code per segment, segment s at [2s+:2] |

## Verification
A phase counter out of step shows up at once on the common pins. The full-swing code moves to the wrong common, or a parked common wakes, on the first edge after the fault. A polarity flip at the wrong moment turns every lit and dark code into its mirror. A stale or wrong row capture shows only on segment pins, and only after a tick or mode change. For that reason the sweep rewrites the segment image in the middle of every phase and checks every pin on every cycle. A lagging general-purpose register shows as a one-cycle error each time the data input toggles.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int NCOM = 4;
    localparam int PW   = $clog2(NCOM);

    typedef enum logic [2:0] {
        MD_STATIC = 3'd0,
        MD_HALF2  = 3'd1,
        MD_HALF3  = 3'd2,
        MD_HALF4  = 3'd3,
        MD_THIRD3 = 3'd4,
        MD_THIRD4 = 3'd5,
        MD_RSV6   = 3'd6,
        MD_RSV7   = 3'd7
    } lcd_mode_e;

    typedef logic [1:0] lvl_t;
    localparam lvl_t LV_GND = 2'd0;
    localparam lvl_t LV_LO  = 2'd1;
    localparam lvl_t LV_HI  = 2'd2;
    localparam lvl_t LV_TOP = 2'd3;

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          pol;
    } frame_t;

    // number of active commons for a scheme
    function automatic logic [2:0] duty_of(input lcd_mode_e m);
        case (m)
            MD_HALF2:            return 3'd2;
            MD_HALF3, MD_THIRD3: return 3'd3;
            MD_HALF4, MD_THIRD4: return 3'd4;
            default:             return 3'd1;
        endcase
    endfunction

    function automatic logic third_bias(input lcd_mode_e m);
        return (m == MD_THIRD3) || (m == MD_THIRD4);
    endfunction

    function automatic lvl_t com_level(input logic [2:0] duty, input logic b3,
                                       input frame_t f, input logic [PW-1:0] idx);
        if ({1'b0, idx} >= duty) return LV_GND;
        if (idx == f.phase)      return f.pol ? LV_GND : LV_TOP;
        if (b3)                  return f.pol ? LV_HI : LV_LO;
        return LV_LO;
    endfunction

    function automatic lvl_t seg_level(input logic b3, input logic on, input logic pol);
        if (on) return pol ? LV_TOP : LV_GND;
        if (b3) return pol ? LV_LO : LV_HI;
        return pol ? LV_GND : LV_TOP;
    endfunction

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_drv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  lcd_mode_e         mode_in,
    output lcd_mode_e         mode_q,
    output frame_t            frame_q,
    output logic              load,
    output logic [PW-1:0]     load_row
);

    logic          restart;
    logic          last;
    logic [2:0]    duty;
    logic [PW-1:0] next_phase;

    assign duty       = duty_of(mode_q);
    assign restart    = (mode_in != mode_q);
    assign last       = (({1'b0, frame_q.phase}) + 3'd1) == duty;
    assign next_phase = last ? '0 : frame_q.phase + PW'(1);
    assign load       = restart | tick;
    assign load_row   = restart ? '0 : next_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            mode_q  <= mode_in;
        end else if (restart) begin
            frame_q <= '0;
            mode_q  <= mode_in;
        end else if (tick) begin
            frame_q.phase <= next_phase;
            if (last) frame_q.pol <= ~frame_q.pol;
        end
    end

    // R5: phase never leaves the active range
    p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, frame_q.phase}) < duty_of(mode_q));

    // R5: wrap inverts polarity and returns to phase 0
    p_wrap_flip_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && last) |=> (frame_q.pol != $past(frame_q.pol)) && (frame_q.phase == '0));

    // R5: no tick, no movement
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(frame_q));

    // R7: scheme change restarts the frame
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (frame_q == '0));

endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch
    import lcd_drv_pkg::*;
#(
    parameter int NSEG      = 25,
    parameter bit RESET_LIT = 1'b1,
    parameter bit GPIO_RST  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [PW-1:0]        row_sel,
    input  logic [NCOM*NSEG-1:0] seg_ram,
    input  logic [NSEG-1:0]      gpio_data,
    output logic [NSEG-1:0]      row_q,
    output logic [NSEG-1:0]      gpio_q
);

    logic [NSEG-1:0] rows [NCOM];
    logic [NSEG-1:0] row_pick;

    for (genvar r = 0; r < NCOM; r++) begin : g_rows
        assign rows[r] = seg_ram[r*NSEG +: NSEG];
    end

    assign row_pick = rows[row_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= {NSEG{RESET_LIT}};
            gpio_q <= {NSEG{GPIO_RST}};
        end else begin
            gpio_q <= gpio_data;
            if (load) row_q <= row_pick;
        end
    end

    // R6: captured row is frozen between phase starts
    p_row_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(row_q));

    // R6: a phase start captures the addressed row
    p_row_load_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (row_q == $past(row_pick)));

    // R9: general-purpose level lags its input by one edge
    p_gpio_follow_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (gpio_q == $past(gpio_data)));

endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
    import lcd_drv_pkg::*;
#(
    parameter int NSEG = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  lcd_mode_e         mode_q,
    input  frame_t            frame_q,
    input  logic [NSEG-1:0]   row_q,
    input  logic [NSEG-1:0]   gpio_sel,
    input  logic [NSEG-1:0]   gpio_q,
    output logic [2*NCOM-1:0] com_lvl,
    output logic [2*NSEG-1:0] seg_lvl
);

    logic [2:0]      duty;
    logic            b3;
    logic [NCOM-1:0] sel_hit;

    assign duty = duty_of(mode_q);
    assign b3   = third_bias(mode_q);

    for (genvar c = 0; c < NCOM; c++) begin : g_com
        localparam logic [PW-1:0] CI = PW'(c);
        assign com_lvl[2*c +: 2] = com_level(duty, b3, frame_q, CI);
        assign sel_hit[c] = ({1'b0, CI} < duty) &&
                            (com_lvl[2*c +: 2] == (frame_q.pol ? LV_GND : LV_TOP));
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign seg_lvl[2*s +: 2] = gpio_sel[s] ? (gpio_q[s] ? LV_TOP : LV_GND)
                                               : seg_level(b3, row_q[s], frame_q.pol);
    end

    // R2: exactly one active common sits on the selecting level
    p_one_select_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_hit) == 1);

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
    import lcd_drv_pkg::*;
#(
    parameter int NSEG      = 25,
    parameter bit RESET_LIT = 1'b1,
    parameter bit GPIO_RST  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [2:0]           mode,
    input  logic [NCOM*NSEG-1:0] seg_ram,
    input  logic [NSEG-1:0]      gpio_sel,
    input  logic [NSEG-1:0]      gpio_data,
    output logic [2*NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]    seg_lvl
);

    lcd_mode_e       mode_q;
    frame_t          frame_q;
    logic            load;
    logic [PW-1:0]   load_row;
    logic [NSEG-1:0] row_q;
    logic [NSEG-1:0] gpio_q;

    lcd_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode_in  (lcd_mode_e'(mode)),
        .mode_q   (mode_q),
        .frame_q  (frame_q),
        .load     (load),
        .load_row (load_row)
    );

    lcd_row_latch #(
        .NSEG      (NSEG),
        .RESET_LIT (RESET_LIT),
        .GPIO_RST  (GPIO_RST)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .row_sel   (load_row),
        .seg_ram   (seg_ram),
        .gpio_data (gpio_data),
        .row_q     (row_q),
        .gpio_q    (gpio_q)
    );

    lcd_level_enc #(
        .NSEG (NSEG)
    ) u_enc (
        .clk      (clk),
        .rst      (rst),
        .mode_q   (mode_q),
        .frame_q  (frame_q),
        .row_q    (row_q),
        .gpio_sel (gpio_sel),
        .gpio_q   (gpio_q),
        .com_lvl  (com_lvl),
        .seg_lvl  (seg_lvl)
    );

endmodule

// File: tb/tb_lcd_mux_driver.sv
`timescale 1ns/1ps
module tb_lcd_mux_driver;

    localparam int NSEG = 25;
    localparam int NC   = 4;
    localparam bit LIT  = 1'b1;
    localparam bit GRST = 1'b0;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                tick = 1'b0;
    logic [2:0]          mode = 3'd0;
    logic [NC*NSEG-1:0]  seg_ram = '0;
    logic [NSEG-1:0]     gpio_sel = '0;
    logic [NSEG-1:0]     gpio_data = '0;
    logic [2*NC-1:0]     com_lvl;
    logic [2*NSEG-1:0]   seg_lvl;

    lcd_mux_driver #(.NSEG(NSEG), .RESET_LIT(LIT), .GPIO_RST(GRST)) dut (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode), .seg_ram(seg_ram),
        .gpio_sel(gpio_sel), .gpio_data(gpio_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string ctx = "";

    // reference state built from the requirements
    int m_ph, m_pl, m_mode;
    logic [NSEG-1:0] m_row, m_gq;

    function automatic int duty(input int m);
        case (m)
            1: return 2;
            2, 4: return 3;
            3, 5: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic bit b3(input int m);
        return (m == 4) || (m == 5);
    endfunction

    function automatic logic [NC*NSEG-1:0] rnd_ram();
        logic [127:0] w;
        w = {$urandom, $urandom, $urandom, $urandom};
        return w[NC*NSEG-1:0];
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_ph = 0; m_pl = 0; m_row = {NSEG{LIT}}; m_gq = {NSEG{GRST}};
            m_mode = int'(mode);
        end else begin
            m_gq = gpio_data;
            if (int'(mode) != m_mode) begin
                m_mode = int'(mode); m_ph = 0; m_pl = 0;
                m_row = seg_ram[0 +: NSEG];
            end else if (tick) begin
                if (m_ph == duty(m_mode) - 1) begin
                    m_ph = 0; m_pl = 1 - m_pl;
                end else m_ph = m_ph + 1;
                m_row = seg_ram[m_ph*NSEG +: NSEG];
            end
        end
    endtask

    task automatic check_pins();
        for (int c = 0; c < NC; c++) begin
            int e; string tag;
            if (c >= duty(m_mode)) begin e = 0; tag = "R1"; end
            else if (c == m_ph) begin e = m_pl ? 0 : 3; tag = "R2"; end
            else begin e = b3(m_mode) ? (m_pl ? 2 : 1) : 1; tag = "R3"; end
            if (m_mode >= 6) tag = "R10";
            total++;
            if (int'(com_lvl[2*c +: 2]) != e) begin
                bad++;
                $display("FAIL %s [%s] com%0d got=%0d exp=%0d", tag, ctx, c, com_lvl[2*c +: 2], e);
            end
        end
        for (int s = 0; s < NSEG; s++) begin
            int e; string tag;
            if (gpio_sel[s]) begin e = m_gq[s] ? 3 : 0; tag = "R9"; end
            else begin
                tag = "R4";
                if (m_row[s]) e = m_pl ? 3 : 0;
                else if (b3(m_mode)) e = m_pl ? 1 : 2;
                else e = m_pl ? 0 : 3;
            end
            if (m_mode >= 6) tag = "R10";
            total++;
            if (int'(seg_lvl[2*s +: 2]) != e) begin
                bad++;
                $display("FAIL %s [%s] seg%0d got=%0d exp=%0d", tag, ctx, s, seg_lvl[2*s +: 2], e);
            end
        end
    endtask

    task automatic cyc(input bit t);
        tick = t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        tick = 1'b0;
        check_pins();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R5 watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        seg_ram   = rnd_ram();
        gpio_sel  = 25'h0AA_AAAA;
        gpio_data = '1;
        ctx = "R8 in reset";
        cyc(1'b0);
        cyc(1'b0);
        rst = 1'b0;
        ctx = "R8 pattern after release, R9 data";
        cyc(1'b0);
        cyc(1'b0);
        for (int m = 0; m < 8; m++) begin
            mode      = 3'(m);
            seg_ram   = rnd_ram();
            gpio_data = ~gpio_data;
            gpio_sel  = NSEG'($urandom) & 25'h1F0_F0F0;
            ctx = "R7 restart";
            cyc(1'b1);
            for (int k = 0; k < 2*duty(m) + 2; k++) begin
                seg_ram = rnd_ram();
                gpio_data = NSEG'($urandom);
                ctx = "R6 mid-phase write";
                cyc(1'b0);
                ctx = "R5 tick";
                cyc(1'b1);
            end
        end
        // scheme change in the middle of a frame, tick ignored
        mode = 3'd5;
        ctx = "R7 mid-frame";
        cyc(1'b1);
        cyc(1'b1);
        mode = 3'd3;
        cyc(1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule